// File: doc/BRIEF.md
# UART Status Flag Clear Sequencer

This block holds four UART status flags and enforces the protocol software must follow to clear them. The flags are transmit-below-watermark, receive-data-full, line-idle and receive-error. Software clears a flag in two steps. First it reads the status register, which arms every flag seen as set at that moment. Later it accesses the data register: a read for the receive-side flags, a write for the transmit flag. Unrelated bus traffic may come between the two steps. A flag routed to DMA can also be cleared directly by a DMA-done pulse. Level-driven flags come back at once when their cause still holds after a clear.

The block sits between a simple register bus and the FIFOs and serial engines, which are outside this block. Data-register reads pop the receive FIFO, and this block keeps the receive read pointer. A read while the receive FIFO is empty still moves that pointer, and only the flush input realigns it. Data-register writes push into the transmit FIFO. The flags drive a combined interrupt line and two DMA request lines.

The clear sequence is tracked by a two-state machine. `SEQ_IDLE` means no flag is armed. The transition *capture* goes to `SEQ_ARMED` when a status read arms at least one flag. From `SEQ_ARMED`, the transition *flush* returns to `SEQ_IDLE` on a receive flush. The transition *drained* returns to `SEQ_IDLE` once the last armed flag has been cleared or disarmed. In every other case the machine holds its state. Data-register accesses can clear flags only while the machine is in `SEQ_ARMED`.

Top module: `uart_flag_clear_seq`

## Requirements
- R1: After reset, all flags and arm bits are 0, `irq`, `tx_dma_req`, `rx_dma_req` and `bus_rdata` are 0, and `rx_rptr` is 0.
- R2: Flag set conditions. The transmit flag (status bit 0) is set in every cycle where `tx_level <= tx_wm`. The receive-full flag (bit 1) is set when `rx_level` is nonzero and `rx_level >= rx_wm`. The idle flag (bit 2) is set by an `idle_evt` pulse and the error flag (bit 3) by an `err_evt` pulse; both stay set until cleared. Any set flag not routed to DMA raises `irq`.
- R3: A read of address 0 (status) returns the flag vector on `bus_rdata` in bits 3:0, one cycle after the strobe. It arms exactly the flags set in the strobe cycle, so an arm bit is never set while its flag is clear.
- R4: A data-register access (address 1) with no armed flag clears nothing.
- R5: An armed data read clears the armed receive-full, idle and error flags and leaves the transmit flag set. An armed data write clears only an armed transmit flag. Reads and writes to addresses 2 and 3 between the two steps do not disarm.
- R6: A flag that becomes set after the status read is not cleared by the following data access.
- R7: When the cause of a level flag still holds in the cycle it is cleared, the flag stays set and its request stays asserted.
- R8: With `rx_dma_en` (or `tx_dma_en`) high, the receive-full (or transmit) flag is left out of `irq` and drives `rx_dma_req` (or `tx_dma_req`). A `rx_dma_done` (or `tx_dma_done`) pulse clears that flag without any status read.
- R9: Every data read pulses `rx_pop` in its strobe cycle, returns `rx_data` on `bus_rdata` one cycle later, and advances `rx_rptr` by one modulo `DEPTH`. This happens even when `rx_level` is 0.
- R10: A data write pulses `tx_push` in its strobe cycle with `tx_push_data` equal to `bus_wdata`.
- R11: A one-cycle `rx_flush` returns `rx_rptr` to 0 and clears all arm bits, so a data read after it clears nothing.
- R12: When `bus_rd` and `bus_wr` are high in the same cycle, the read is performed and the write is ignored (no `tx_push`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after the strobe |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_wm | input | LVL_W | Transmit watermark |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_wm | input | LVL_W | Receive watermark |
| idle_evt | input | 1 | Line-idle event pulse |
| err_evt | input | 1 | Receive error event pulse |
| tx_dma_en | input | 1 | Route transmit flag to DMA |
| rx_dma_en | input | 1 | Route receive-full flag to DMA |
| tx_dma_done | input | 1 | Transmit DMA done pulse |
| rx_dma_done | input | 1 | Receive DMA done pulse |
| rx_flush | input | 1 | Receive pointer and arm flush |
| rx_data | input | DW | Receive FIFO head word |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_push_data | output | DW | Word pushed into transmit FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_rptr | output | PTR_W | Receive read pointer |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The clearing function is tried with four access patterns:
- A data access with nothing armed, which separates a design that requires the status read from one that clears on any data access.
- A full status-then-data sequence with accesses to other addresses in between, which shows that unrelated traffic does not break the sequence.
- A second event arriving between the two steps, which separates per-flag arming from a single global arm.
- A read against a write-class flag and the reverse, which shows the access type is honoured.

Level flags are cleared while their cause persists, to show they re-assert. Reads of an empty receive FIFO followed by a flush exercise the pointer drift and its recovery. DMA routing is checked for both request redirection and direct clearing.

// File: rtl/uart_fcs_pkg.sv
package uart_fcs_pkg;

    localparam int NFLAG     = 4;
    localparam int FL_TXWM   = 0;
    localparam int FL_RXFULL = 1;
    localparam int FL_IDLE   = 2;
    localparam int FL_ERR    = 3;

    localparam int ADDR_STAT = 0;
    localparam int ADDR_DATA = 1;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_ARMED
    } seq_state_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STAT_RD,
        ACC_DATA_RD,
        ACC_DATA_WR,
        ACC_OTHER
    } acc_kind_e;

endpackage

// File: rtl/uart_fcs_bus_dec.sv
module uart_fcs_bus_dec
    import uart_fcs_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_kind_e         acc
);

    // Read takes precedence when both strobes are high.
    always_comb begin
        acc = ACC_NONE;
        if (rd) begin
            if (addr == ADDR_W'(ADDR_STAT))
                acc = ACC_STAT_RD;
            else if (addr == ADDR_W'(ADDR_DATA))
                acc = ACC_DATA_RD;
            else
                acc = ACC_OTHER;
        end else if (wr) begin
            if (addr == ADDR_W'(ADDR_DATA))
                acc = ACC_DATA_WR;
            else
                acc = ACC_OTHER;
        end
    end

endmodule

// File: rtl/uart_fcs_flag_cell.sv
module uart_fcs_flag_cell #(
    parameter bit READ_CLASS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cond,
    input  logic stat_rd,
    input  logic data_rd,
    input  logic data_wr,
    input  logic flush,
    input  logic dma_clr,
    input  logic seq_open,
    output logic flag_q,
    output logic arm_q,
    output logic arm_nxt
);

    logic acc_hit;
    logic clr;
    logic flag_nxt;

    generate
        if (READ_CLASS) begin : g_rd_class
            assign acc_hit = data_rd;
        end else begin : g_wr_class
            assign acc_hit = data_wr;
        end
    endgenerate

    assign clr = (seq_open & arm_q & acc_hit) | dma_clr;

    // Set wins over clear so a persisting cause keeps the flag up.
    assign flag_nxt = (flag_q & ~clr) | set_cond;

    always_comb begin
        if (flush)
            arm_nxt = 1'b0;
        else if (stat_rd)
            arm_nxt = flag_q & ~dma_clr;
        else if (clr)
            arm_nxt = 1'b0;
        else
            arm_nxt = arm_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= flag_nxt;
            arm_q  <= arm_nxt;
        end
    end

endmodule

// File: rtl/uart_fcs_seq_fsm.sv
module uart_fcs_seq_fsm
    import uart_fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic any_arm_nxt,
    output logic seq_open
);

    seq_state_e state_q;
    seq_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (!flush && any_arm_nxt)
                    state_n = SEQ_ARMED;      // capture
            end
            SEQ_ARMED: begin
                if (flush)
                    state_n = SEQ_IDLE;       // flush
                else if (!any_arm_nxt)
                    state_n = SEQ_IDLE;       // drained
            end
            default: state_n = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_n;
    end

    always_comb begin
        seq_open = (state_q == SEQ_ARMED);
    end

endmodule

// File: rtl/uart_fcs_rx_ptr.sv
module uart_fcs_rx_ptr #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pop,
    output logic [PTR_W-1:0] rptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // Advances on every pop, empty or not; only a flush realigns it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rptr <= '0;
        else if (flush)
            rptr <= '0;
        else if (pop)
            rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end

endmodule

// File: rtl/uart_flag_clear_seq.sv
module uart_flag_clear_seq
    import uart_fcs_pkg::*;
#(
    parameter int DW     = 8,
    parameter int ADDR_W = 2,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  tx_wm,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rx_wm,
    input  logic              idle_evt,
    input  logic              err_evt,
    input  logic              tx_dma_en,
    input  logic              rx_dma_en,
    input  logic              tx_dma_done,
    input  logic              rx_dma_done,
    input  logic              rx_flush,
    input  logic [DW-1:0]     rx_data,
    output logic              tx_push,
    output logic [DW-1:0]     tx_push_data,
    output logic              rx_pop,
    output logic [PTR_W-1:0]  rx_rptr,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);

    acc_kind_e        acc;
    logic             stat_rd;
    logic             data_rd;
    logic             data_wr;
    logic             any_rd;
    logic             seq_open;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] dma_clr_vec;
    logic [NFLAG-1:0] dma_mask;
    logic [NFLAG-1:0] flag_vec;
    logic [NFLAG-1:0] arm_vec;
    logic [NFLAG-1:0] arm_nxt_vec;

    uart_fcs_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .acc  (acc)
    );

    assign stat_rd = (acc == ACC_STAT_RD);
    assign data_rd = (acc == ACC_DATA_RD);
    assign data_wr = (acc == ACC_DATA_WR);
    assign any_rd  = bus_rd;

    always_comb begin
        set_vec            = '0;
        set_vec[FL_TXWM]   = (tx_level <= tx_wm);
        set_vec[FL_RXFULL] = (rx_level != '0) && (rx_level >= rx_wm);
        set_vec[FL_IDLE]   = idle_evt;
        set_vec[FL_ERR]    = err_evt;

        dma_mask            = '0;
        dma_mask[FL_TXWM]   = tx_dma_en;
        dma_mask[FL_RXFULL] = rx_dma_en;

        dma_clr_vec            = '0;
        dma_clr_vec[FL_TXWM]   = tx_dma_en & tx_dma_done;
        dma_clr_vec[FL_RXFULL] = rx_dma_en & rx_dma_done;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        localparam bit RCLASS = (i != FL_TXWM);
        uart_fcs_flag_cell #(.READ_CLASS(RCLASS)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_cond (set_vec[i]),
            .stat_rd  (stat_rd),
            .data_rd  (data_rd),
            .data_wr  (data_wr),
            .flush    (rx_flush),
            .dma_clr  (dma_clr_vec[i]),
            .seq_open (seq_open),
            .flag_q   (flag_vec[i]),
            .arm_q    (arm_vec[i]),
            .arm_nxt  (arm_nxt_vec[i])
        );
    end

    uart_fcs_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (rx_flush),
        .any_arm_nxt (|arm_nxt_vec),
        .seq_open    (seq_open)
    );

    uart_fcs_rx_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .pop   (data_rd),
        .rptr  (rx_rptr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (any_rd) begin
            if (stat_rd)
                bus_rdata <= DW'(flag_vec);
            else if (data_rd)
                bus_rdata <= rx_data;
            else
                bus_rdata <= '0;
        end
    end

    assign tx_push      = data_wr;
    assign tx_push_data = bus_wdata;
    assign rx_pop       = data_rd;
    assign irq          = |(flag_vec & ~dma_mask);
    assign tx_dma_req   = flag_vec[FL_TXWM] & tx_dma_en;
    assign rx_dma_req   = flag_vec[FL_RXFULL] & rx_dma_en;

endmodule

// File: rtl/uart_fcs_chk.sv
module uart_fcs_chk #(
    parameter int PTR_W = 4,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       flag_q,
    input logic [3:0]       arm_q,
    input logic             rx_flush,
    input logic             rx_pop,
    input logic [PTR_W-1:0] rx_rptr,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] tx_wm
);

    a_r3_arm_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q & ~flag_q) == 4'b0000);

    a_r4_err_kept_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[3] && !arm_q[3]) |=> flag_q[3]);

    a_r4_idle_kept_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[2] && !arm_q[2]) |=> flag_q[2]);

    a_r7_txwm_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_wm) |=> flag_q[0]);

    a_r9_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_flush) |=> (rx_rptr != $past(rx_rptr)));

    a_r11_flush_resets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (arm_q == 4'b0000 && rx_rptr == '0));

endmodule

bind uart_flag_clear_seq uart_fcs_chk #(.PTR_W(PTR_W), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_q   (flag_vec),
    .arm_q    (arm_vec),
    .rx_flush (rx_flush),
    .rx_pop   (rx_pop),
    .rx_rptr  (rx_rptr),
    .tx_level (tx_level),
    .tx_wm    (tx_wm)
);

// File: tb/tb_uart_flag_clear_seq.sv
module tb_uart_flag_clear_seq;

    localparam int DW = 8;
    localparam int AW = 2;
    localparam int DEPTH = 16;
    localparam int PW = 4;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic [LW-1:0] tx_level = 5'd8, tx_wm = 5'd2, rx_level = 5'd0, rx_wm = 5'd4;
    logic          idle_evt = 1'b0, err_evt = 1'b0;
    logic          tx_dma_en = 1'b0, rx_dma_en = 1'b0;
    logic          tx_dma_done = 1'b0, rx_dma_done = 1'b0, rx_flush = 1'b0;
    logic [DW-1:0] rx_data = 8'h3C;
    logic          tx_push, rx_pop, irq, tx_dma_req, rx_dma_req;
    logic [DW-1:0] tx_push_data;
    logic [PW-1:0] rx_rptr;

    int n_chk = 0, n_fail = 0, exp_rptr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_flag_clear_seq #(.DW(DW), .ADDR_W(AW), .DEPTH(DEPTH)) dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input int a);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 1) exp_rptr = (exp_rptr + 1) % DEPTH;
    endtask

    task automatic bus_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic stat_is(input string tag, input logic [3:0] exp);
        bus_read(0);
        chk(tag, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic pulse_err();
        @(negedge clk); err_evt = 1'b1; @(negedge clk); err_evt = 1'b0;
    endtask

    task automatic pulse_idle();
        @(negedge clk); idle_evt = 1'b1; @(negedge clk); idle_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", 32'(bus_rdata), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dma req", 32'({tx_dma_req, rx_dma_req}), 0);
        chk("R1 rptr", 32'(rx_rptr), 0);
        stat_is("R1 status", 4'h0);
    endtask

    task automatic t_err_sequence();
        pulse_err();
        chk("R2 irq on err", 32'(irq), 1);
        bus_read(1);
        stat_is("R4 unarmed data read", 4'h8);
        bus_read(1);
        chk("R5 err cleared irq", 32'(irq), 0);
        stat_is("R5 err cleared", 4'h0);
    endtask

    task automatic t_unrelated_between();
        pulse_idle();
        stat_is("R2 idle set", 4'h4);
        bus_write(2, 8'h11);
        bus_read(3);
        bus_write(0, 8'hFF);
        bus_read(1);
        stat_is("R5 idle cleared past other accesses", 4'h0);
    endtask

    task automatic t_only_seen();
        pulse_idle();
        stat_is("R6 idle armed", 4'h4);
        pulse_err();
        bus_read(1);
        stat_is("R6 late err kept", 4'h8);
        bus_read(1);
        stat_is("R6 err then cleared", 4'h0);
    endtask

    task automatic t_tx();
        @(negedge clk); tx_level = 5'd1;
        @(negedge clk);
        chk("R2 txwm irq", 32'(irq), 1);
        stat_is("R2 txwm set", 4'h1);
        @(negedge clk);
        bus_addr = 2'd1; bus_wr = 1'b1; bus_wdata = 8'hA5;
        #1;
        chk("R10 tx_push", 32'(tx_push), 1);
        chk("R10 tx_push_data", 32'(tx_push_data), 32'h A5);
        @(negedge clk); bus_wr = 1'b0;
        chk("R7 txwm persists irq", 32'(irq), 1);
        stat_is("R7 txwm persists", 4'h1);
        @(negedge clk); tx_level = 5'd5;
        stat_is("R2 txwm sticky", 4'h1);
        bus_read(1);
        stat_is("R5 read leaves txwm", 4'h1);
        bus_write(1, 8'h5A);
        stat_is("R5 write clears txwm", 4'h0);
        chk("R9 rptr after reads", 32'(rx_rptr), 32'(exp_rptr));
    endtask

    task automatic t_rx();
        @(negedge clk); rx_level = 5'd5; rx_data = 8'h3C;
        stat_is("R2 rxfull set", 4'h2);
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1;
        #1;
        chk("R9 rx_pop", 32'(rx_pop), 1);
        @(negedge clk); bus_rd = 1'b0;
        exp_rptr = (exp_rptr + 1) % DEPTH;
        chk("R9 rdata", 32'(bus_rdata), 32'h3C);
        chk("R9 rptr", 32'(rx_rptr), 32'(exp_rptr));
        stat_is("R7 rxfull reasserts", 4'h2);
        @(negedge clk); rx_level = 5'd0;
        stat_is("R2 rxfull sticky", 4'h2);
        bus_read(1);
        chk("R9 empty read advances", 32'(rx_rptr), 32'(exp_rptr));
        stat_is("R5 rxfull cleared", 4'h0);
    endtask

    task automatic t_dma();
        @(negedge clk); rx_dma_en = 1'b1; rx_level = 5'd5;
        @(negedge clk);
        chk("R8 rx dma req", 32'(rx_dma_req), 1);
        chk("R8 irq masked", 32'(irq), 0);
        @(negedge clk); rx_level = 5'd0; rx_dma_done = 1'b1;
        @(negedge clk); rx_dma_done = 1'b0;
        chk("R8 dma done clears", 32'(rx_dma_req), 0);
        rx_dma_en = 1'b0;
        @(negedge clk);
        chk("R8 flag gone", 32'(irq), 0);
    endtask

    task automatic t_flush();
        pulse_err();
        stat_is("R11 err armed", 4'h8);
        @(negedge clk); rx_flush = 1'b1;
        @(negedge clk); rx_flush = 1'b0;
        exp_rptr = 0;
        chk("R11 rptr zero", 32'(rx_rptr), 0);
        bus_read(1);
        stat_is("R11 read after flush clears nothing", 4'h8);
        bus_read(1);
        stat_is("R11 cleanup", 4'h0);
        chk("R11 rptr after", 32'(rx_rptr), 32'(exp_rptr));
    endtask

    task automatic t_wrap();
        for (int k = 0; k < DEPTH; k++) bus_read(1);
        chk("R9 rptr wraps", 32'(rx_rptr), 32'(exp_rptr));
    endtask

    task automatic t_rd_prec();
        @(negedge clk);
        bus_addr = 2'd1; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h77;
        #1;
        chk("R12 no push", 32'(tx_push), 0);
        chk("R12 pop", 32'(rx_pop), 1);
        @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
        exp_rptr = (exp_rptr + 1) % DEPTH;
        chk("R12 rptr", 32'(rx_rptr), 32'(exp_rptr));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_err_sequence();
        t_unrelated_between();
        t_only_seen();
        t_tx();
        t_rx();
        t_dma();
        t_flush();
        t_wrap();
        t_rd_prec();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule